// File: doc/BRIEF.md
# Parallel Port Mode Negotiation and Termination Sequencer

This block sits on the host side of a bidirectional parallel printer port. It moves a peripheral out of the default compatibility mode into an extended mode chosen by a one-byte request code. Later, on request, it brings the link back to compatibility. It drives the four host control lines and the eight data lines, and it samples the five peripheral status lines through two-flop synchronizers. Every wait for a peripheral response is bounded by a tick count set by a parameter.

A controller asks for a mode by pulsing `start_i` with the request byte on `mode_i`. It asks for a return to compatibility by pulsing `term_i`. Each operation ends with a one-cycle `done_o` pulse. At that pulse, `status_o` holds one of four codes: 0 = success, 1 = mode refused, 2 = response timeout, 3 = I/O error. While an extended mode is in force, `active_o` is high and `cur_mode_o` holds its request byte.

Named states:
- `ST_IDLE`
- `ST_SETUP`: request byte driven, setup delay running.
- `ST_WAIT_RESP`: selection raised, waiting for the peripheral to answer.
- `ST_STROBE`: request latched by a strobe pulse.
- `ST_WAIT_LATCH`: strobe released, waiting for the peripheral to latch its answer.
- `ST_TREQ`: return requested, waiting for the peripheral to acknowledge.
- `ST_THSK`: host handshake, waiting for the peripheral's reply.
- `ST_TFIN`: auto-feed high again, result reported.

Transitions:
- IDLE to SETUP on start. IDLE to TREQ on term. IDLE to IDLE with an error on a start that is refused.
- SETUP to WAIT_RESP when the setup delay expires.
- WAIT_RESP to STROBE on a response, or to IDLE on timeout.
- STROBE to WAIT_LATCH when the pause expires.
- WAIT_LATCH to IDLE on the latch or on timeout.
- TREQ to THSK on acknowledge, or to TFIN on timeout.
- THSK to TFIN on the reply or on timeout.
- TFIN to IDLE.

Top module: `p1284_neg_ctrl`

## Requirements
- R1: A start pulse received while `sel_in_n_o` is high yields `done_o` with status 3 and no change on any host line.
- R2: On a start, the request byte appears on `data_o` and stays there. `sel_in_n_o` rises no earlier than T_SETUP cycles after the start pulse.
- R3: Once the setup delay ends, `sel_in_n_o` is driven high and `autofd_n_o` low, while `strobe_n_o` and `init_n_o` stay high.
- R4: The block then waits for PError, Select and nFault high with nAck low. If they do not arrive, it ends with status 2 between T_RESP and T_RESP+3 cycles after `sel_in_n_o` rose.
- R5: After that response, `strobe_n_o` goes low for at least T_PAUSE cycles. Then `strobe_n_o` and `autofd_n_o` both return high.
- R6: If nAck does not then return high within T_SETUP+T_RESP cycles, the block ends with status 3.
- R7: On a completed handshake, request byte 0x00 always gives status 0. Any other byte gives status 0 only if Select is high, and status 1 otherwise. On status 0, `active_o` rises and `cur_mode_o` takes the request byte.
- R8: A term pulse drives `sel_in_n_o` low and `autofd_n_o` high. It waits for Busy and nFault high with nAck low, then lowers `autofd_n_o`. After nAck goes high, it raises `autofd_n_o` and ends with status 0.
- R9: `active_o` falls and `cur_mode_o` clears as soon as the acknowledge wait of R8 ends, even on a timeout. A timeout there ends with status 3.
- R10: If the nAck-high wait during termination times out, `autofd_n_o` is high again when `done_o` reports status 3.
- R11: `done_o` is high for exactly one cycle per operation.
- R12: After reset, `sel_in_n_o` and `data_o` are low, the other host lines are high, and `done_o` and `active_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: negotiate the mode in `mode_i` |
| mode_i | input | 8 | Request byte |
| term_i | input | 1 | Pulse: return to compatibility |
| data_o | output | 8 | Port data lines |
| strobe_n_o | output | 1 | Strobe line, active low |
| autofd_n_o | output | 1 | Auto-feed line, active low |
| sel_in_n_o | output | 1 | Select-in line, active low |
| init_n_o | output | 1 | Initialise line, active low |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| busy_i | input | 1 | Peripheral busy |
| perror_i | input | 1 | Peripheral paper-error line |
| select_i | input | 1 | Peripheral select |
| fault_n_i | input | 1 | Peripheral fault, active low |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result code, valid with `done_o` |
| active_o | output | 1 | Extended mode in force |
| cur_mode_o | output | 8 | Request byte of the mode in force |

## Verification
The bench builds the block with T_SETUP = 3, T_RESP = 8 and T_PAUSE = 2. These small values keep every timeout and setup window short, so each can be checked against exact cycle bounds. They also make it cheap to sweep all 256 request bytes against both Select levels, each followed by a return to compatibility. A reactive peripheral model can withhold any one of its four responses, which reaches every timeout and error exit.

// File: rtl/p1284_neg_pkg.sv
package p1284_neg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_RESP,
        ST_STROBE,
        ST_WAIT_LATCH,
        ST_TREQ,
        ST_THSK,
        ST_TFIN
    } neg_state_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NOSUP   = 2'd1,
        RES_TIMEOUT = 2'd2,
        RES_IOERR   = 2'd3
    } neg_result_t;

    localparam int unsigned IN_W = 5;

endpackage

// File: rtl/p1284_sync.sv
module p1284_sync #(
    parameter int unsigned W = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d_i[i];
                s2 <= s1;
            end
        end
        assign q_o[i] = s2;
    end
endmodule

// File: rtl/p1284_wait_timer.sv
module p1284_wait_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load_i)           cnt_q <= limit_i;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/p1284_neg_ctrl.sv
module p1284_neg_ctrl
    import p1284_neg_pkg::*;
#(
    parameter int unsigned T_SETUP = 3,
    parameter int unsigned T_RESP  = 8,
    parameter int unsigned T_PAUSE = 2,
    parameter int unsigned DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] mode_i,
    input  logic          term_i,
    output logic [DW-1:0] data_o,
    output logic          strobe_n_o,
    output logic          autofd_n_o,
    output logic          sel_in_n_o,
    output logic          init_n_o,
    input  logic          ack_n_i,
    input  logic          busy_i,
    input  logic          perror_i,
    input  logic          select_i,
    input  logic          fault_n_i,
    output logic          done_o,
    output logic [1:0]    status_o,
    output logic          active_o,
    output logic [DW-1:0] cur_mode_o
);
    localparam int unsigned T_LONG = T_SETUP + T_RESP;
    localparam int unsigned T_MAX  = (T_LONG > T_PAUSE) ? T_LONG : T_PAUSE;
    localparam int unsigned CW     = $clog2(T_MAX + 1) + 1;

    // synchronized peripheral lines {ack_n, busy, perror, select, fault_n}
    logic [IN_W-1:0] pin_s;
    logic ack_n_s, busy_s, perror_s, select_s, fault_n_s;

    p1284_sync #(.W(IN_W), .RST_VAL(5'b10001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ack_n_i, busy_i, perror_i, select_i, fault_n_i}),
        .q_o   (pin_s)
    );
    assign {ack_n_s, busy_s, perror_s, select_s, fault_n_s} = pin_s;

    neg_state_t  st_q, st_d;
    logic        tfail_q, tfail_set;
    logic        fin, acc, clr;
    neg_result_t fin_res;
    logic        tmr_exp;
    logic [CW-1:0] tmr_lim;

    always_comb begin
        unique case (st_d)
            ST_SETUP:      tmr_lim = CW'(T_SETUP);
            ST_WAIT_RESP:  tmr_lim = CW'(T_RESP);
            ST_STROBE:     tmr_lim = CW'(T_PAUSE);
            ST_WAIT_LATCH: tmr_lim = CW'(T_LONG);
            ST_TREQ:       tmr_lim = CW'(T_LONG);
            ST_THSK:       tmr_lim = CW'(T_RESP);
            default:       tmr_lim = '0;
        endcase
    end

    p1284_wait_timer #(.CW(CW)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (st_q != st_d),
        .limit_i   (tmr_lim),
        .expired_o (tmr_exp)
    );

    // next-state and completion decisions
    always_comb begin
        st_d      = st_q;
        fin       = 1'b0;
        fin_res   = RES_OK;
        acc       = 1'b0;
        clr       = 1'b0;
        tfail_set = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (sel_in_n_o) begin
                        fin     = 1'b1;
                        fin_res = RES_IOERR;
                    end else begin
                        st_d = ST_SETUP;
                    end
                end else if (term_i) begin
                    st_d = ST_TREQ;
                end
            end
            ST_SETUP: if (tmr_exp) st_d = ST_WAIT_RESP;
            ST_WAIT_RESP: begin
                if (perror_s && select_s && fault_n_s && !ack_n_s) begin
                    st_d = ST_STROBE;
                end else if (tmr_exp) begin
                    st_d    = ST_IDLE;
                    fin     = 1'b1;
                    fin_res = RES_TIMEOUT;
                end
            end
            ST_STROBE: if (tmr_exp) st_d = ST_WAIT_LATCH;
            ST_WAIT_LATCH: begin
                if (ack_n_s) begin
                    st_d = ST_IDLE;
                    fin  = 1'b1;
                    if (data_o == '0 || select_s) begin
                        acc     = 1'b1;
                        fin_res = RES_OK;
                    end else begin
                        fin_res = RES_NOSUP;
                    end
                end else if (tmr_exp) begin
                    st_d    = ST_IDLE;
                    fin     = 1'b1;
                    fin_res = RES_IOERR;
                end
            end
            ST_TREQ: begin
                if (busy_s && fault_n_s && !ack_n_s) begin
                    st_d = ST_THSK;
                    clr  = 1'b1;
                end else if (tmr_exp) begin
                    st_d      = ST_TFIN;
                    clr       = 1'b1;
                    tfail_set = 1'b1;
                end
            end
            ST_THSK: begin
                if (ack_n_s) begin
                    st_d = ST_TFIN;
                end else if (tmr_exp) begin
                    st_d      = ST_TFIN;
                    tfail_set = 1'b1;
                end
            end
            ST_TFIN: begin
                st_d    = ST_IDLE;
                fin     = 1'b1;
                fin_res = tfail_q ? RES_IOERR : RES_OK;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            tfail_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE)  tfail_q <= 1'b0;
            else if (tfail_set)   tfail_q <= 1'b1;
        end
    end

    // outputs: line levels follow the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o     <= '0;
            strobe_n_o <= 1'b1;
            autofd_n_o <= 1'b1;
            sel_in_n_o <= 1'b0;
            done_o     <= 1'b0;
            status_o   <= RES_OK;
            active_o   <= 1'b0;
            cur_mode_o <= '0;
        end else begin
            if (st_q != st_d) begin
                unique case (st_d)
                    ST_SETUP:      data_o <= mode_i;
                    ST_WAIT_RESP: begin
                        sel_in_n_o <= 1'b1;
                        autofd_n_o <= 1'b0;
                        strobe_n_o <= 1'b1;
                    end
                    ST_STROBE:     strobe_n_o <= 1'b0;
                    ST_WAIT_LATCH: begin
                        strobe_n_o <= 1'b1;
                        autofd_n_o <= 1'b1;
                    end
                    ST_TREQ: begin
                        sel_in_n_o <= 1'b0;
                        autofd_n_o <= 1'b1;
                        strobe_n_o <= 1'b1;
                    end
                    ST_THSK:       autofd_n_o <= 1'b0;
                    ST_TFIN:       autofd_n_o <= 1'b1;
                    default: ;
                endcase
            end
            done_o <= fin;
            if (fin) status_o <= fin_res;
            if (acc) begin
                active_o   <= 1'b1;
                cur_mode_o <= data_o;
            end else if (clr) begin
                active_o   <= 1'b0;
                cur_mode_o <= '0;
            end
        end
    end

    assign init_n_o = 1'b1;

    // R1: refused start leaves the lines alone and reports an I/O error
    a_r1_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start_i && sel_in_n_o)
        |=> (done_o && status_o == RES_IOERR && sel_in_n_o && $stable(data_o)));

    // R2: request byte held throughout an operation
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(data_o));

    // R5: strobe only low during the latch pulse
    a_r5_strobe_in_e3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n_o |-> (st_q == ST_STROBE));

    // R9: mode already cleared during the host handshake
    a_r9_cleared_in_e25: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_THSK) |-> (!active_o && cur_mode_o == '0));

    // R10: auto-feed high whenever a termination completes
    a_r10_afd_high_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_TFIN) |-> (autofd_n_o && done_o));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/sim_p1284_neg_ctrl.sv
module sim_p1284_neg_ctrl;
    localparam int T_SETUP = 3;
    localparam int T_RESP  = 8;
    localparam int T_PAUSE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, term_i = 1'b0;
    logic [7:0] mode_i = '0;
    logic [7:0] data_o, cur_mode_o;
    logic strobe_n_o, autofd_n_o, sel_in_n_o, init_n_o, done_o, active_o;
    logic [1:0] status_o;
    logic ack_n_i, busy_i, perror_i, select_i, fault_n_i;

    int checks = 0, errors = 0;

    // peripheral model knobs
    logic en_n2 = 0, en_n6 = 0, en_t1 = 0, en_t2 = 0, sel_knob = 0, clr_req = 1;
    logic seen_stb = 0;

    always #2 clk = ~clk;

    p1284_neg_ctrl #(.T_SETUP(T_SETUP), .T_RESP(T_RESP), .T_PAUSE(T_PAUSE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .term_i(term_i),
        .data_o(data_o), .strobe_n_o(strobe_n_o), .autofd_n_o(autofd_n_o),
        .sel_in_n_o(sel_in_n_o), .init_n_o(init_n_o), .ack_n_i(ack_n_i),
        .busy_i(busy_i), .perror_i(perror_i), .select_i(select_i),
        .fault_n_i(fault_n_i), .done_o(done_o), .status_o(status_o),
        .active_o(active_o), .cur_mode_o(cur_mode_o));

    always @(negedge clk) begin
        if (clr_req) begin
            ack_n_i <= 1'b1; busy_i <= 1'b0; perror_i <= 1'b0;
            select_i <= 1'b0; fault_n_i <= 1'b1; seen_stb <= 1'b0;
        end else begin
            if (!strobe_n_o) seen_stb <= 1'b1;
            if (!sel_in_n_o) seen_stb <= 1'b0;
            if (en_t1 && !sel_in_n_o && autofd_n_o) begin
                busy_i <= 1'b1; fault_n_i <= 1'b1; ack_n_i <= 1'b0;
            end
            if (en_t2 && !sel_in_n_o && !autofd_n_o) ack_n_i <= 1'b1;
            if (en_n2 && sel_in_n_o && !autofd_n_o && strobe_n_o && !seen_stb) begin
                perror_i <= 1'b1; select_i <= 1'b1; fault_n_i <= 1'b1; ack_n_i <= 1'b0;
            end
            if (en_n6 && seen_stb && sel_in_n_o && autofd_n_o && strobe_n_o) begin
                ack_n_i <= 1'b1; select_i <= sel_knob;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic periph(input logic n2, input logic n6, input logic s,
                          input logic t1, input logic t2);
        @(negedge clk);
        clr_req = 1;
        @(negedge clk);
        en_n2 = n2; en_n6 = n6; sel_knob = s; en_t1 = t1; en_t2 = t2;
        clr_req = 0;
    endtask

    // negotiation: returns status, cycles start->sel rise, sel rise->done, strobe-low length
    task automatic negotiate(input logic [7:0] m, input bit check_lines,
                             output int st, output int t_sel, output int t_done,
                             output int stb_len);
        bit sel_seen = 0;
        int cyc = 0;
        t_sel = -1; t_done = -1; stb_len = 0; st = -1;
        @(negedge clk);
        mode_i = m; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 200; i++) begin
            cyc++;
            if (!sel_seen && sel_in_n_o) begin
                sel_seen = 1; t_sel = cyc;
                if (check_lines) begin
                    chk(data_o == m, "R2 data", int'(data_o), int'(m));
                    chk(!autofd_n_o && strobe_n_o && init_n_o, "R3 lines",
                        int'({autofd_n_o, strobe_n_o, init_n_o}), 3);
                end
            end
            if (!strobe_n_o) begin
                stb_len++;
                if (check_lines)
                    chk(!autofd_n_o && sel_in_n_o, "R5 strobe context",
                        int'({autofd_n_o, sel_in_n_o}), 1);
            end
            if (done_o) begin
                st = int'(status_o);
                t_done = cyc - t_sel;
                break;
            end
            @(negedge clk);
        end
        if (st < 0) chk(0, "watchdog negotiate", 0, 1);
    endtask

    task automatic terminate(output int st, output bit saw_afd_low);
        st = -1; saw_afd_low = 0;
        @(negedge clk);
        term_i = 1;
        @(negedge clk);
        term_i = 0;
        for (int i = 0; i < 200; i++) begin
            if (!autofd_n_o && !sel_in_n_o) saw_afd_low = 1;
            if (done_o) begin
                st = int'(status_o);
                break;
            end
            @(negedge clk);
        end
        if (st < 0) chk(0, "watchdog terminate", 0, 1);
    endtask

    initial begin
        int st, ts, td, sl, exp_st;
        bit afl;
        logic [7:0] d_before;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!sel_in_n_o && strobe_n_o && autofd_n_o && init_n_o && data_o == 0
            && !done_o && !active_o, "R12 reset", 0, 0);
        rst_n = 1;

        // R7/R8 exhaustive sweep of request bytes and Select levels
        for (int s = 0; s < 2; s++) begin
            for (int m = 0; m < 256; m++) begin
                periph(1, 1, s[0], 0, 0);
                negotiate(m[7:0], (m % 37) == 0, st, ts, td, sl);
                exp_st = (m == 0 || s == 1) ? 0 : 1;
                chk(st == exp_st, "R7 status", st, exp_st);
                chk(active_o == (exp_st == 0), "R7 active", int'(active_o), int'(exp_st == 0));
                chk(cur_mode_o == ((exp_st == 0) ? m[7:0] : 8'd0), "R7 cur_mode",
                    int'(cur_mode_o), (exp_st == 0) ? m : 0);
                if ((m % 37) == 0) begin
                    chk(ts >= T_SETUP + 1, "R2 setup delay", ts, T_SETUP + 1);
                    chk(sl >= T_PAUSE, "R5 strobe width", sl, T_PAUSE);
                    chk(strobe_n_o && autofd_n_o, "R5 released", int'({strobe_n_o, autofd_n_o}), 3);
                end
                periph(0, 0, 0, 1, 1);
                terminate(st, afl);
                chk(st == 0, "R8 term status", st, 0);
                chk(afl, "R8 autofd low phase", int'(afl), 1);
                chk(!sel_in_n_o && autofd_n_o && !active_o, "R8 final lines",
                    int'({sel_in_n_o, autofd_n_o, active_o}), 2);
            end
        end

        // R1 start while selection high
        periph(1, 1, 1, 0, 0);
        negotiate(8'h10, 0, st, ts, td, sl);
        d_before = data_o;
        negotiate(8'h22, 0, st, ts, td, sl);
        chk(st == 3, "R1 status", st, 3);
        chk(sel_in_n_o && data_o == d_before && autofd_n_o && strobe_n_o, "R1 lines",
            int'(data_o), int'(d_before));
        chk(active_o && cur_mode_o == 8'h10, "R1 mode kept", int'(cur_mode_o), 16);

        // R9 acknowledge timeout during termination
        periph(0, 0, 0, 0, 0);
        terminate(st, afl);
        chk(st == 3, "R9 status", st, 3);
        chk(!active_o && cur_mode_o == 0, "R9 cleared", int'(active_o), 0);

        // R4 response timeout
        periph(0, 1, 1, 0, 0);
        negotiate(8'h10, 0, st, ts, td, sl);
        chk(st == 2, "R4 status", st, 2);
        chk(td >= T_RESP && td <= T_RESP + 3, "R4 latency", td, T_RESP);
        chk(!active_o, "R4 inactive", int'(active_o), 0);

        // R6 latch timeout
        periph(0, 0, 0, 1, 1);
        terminate(st, afl);
        periph(1, 0, 1, 0, 0);
        negotiate(8'h10, 0, st, ts, td, sl);
        chk(st == 3, "R6 status", st, 3);
        chk(!active_o, "R6 inactive", int'(active_o), 0);

        // R10 reply timeout after host handshake
        periph(0, 0, 0, 1, 1);
        terminate(st, afl);
        periph(1, 1, 1, 0, 0);
        negotiate(8'h30, 0, st, ts, td, sl);
        periph(0, 0, 0, 1, 0);
        terminate(st, afl);
        chk(st == 3, "R10 status", st, 3);
        chk(afl, "R10 autofd went low", int'(afl), 1);
        chk(autofd_n_o, "R10 autofd restored", int'(autofd_n_o), 1);
        chk(!active_o, "R9 cleared before reply wait", int'(active_o), 0);

        // R11 single-cycle done
        @(negedge clk);
        chk(!done_o, "R11 done pulse", int'(done_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule